// File: doc/BRIEF.md
# Monte-Carlo Walk Switch and Accumulate Cell

This block is one cell of an unrolled array that follows random walks for a matrix inversion. Each cell holds two pipeline stages, a selector followed by a weighting accumulator. The selector compares a walk state index with a row tag. When they are equal, it replaces the travelling transition term with a per-row scale value. The accumulator multiplies the walk weight by that term to form the next weight. When a column tag equals the state, the accumulator adds the new weight into a running sum. Every quantity the next cell needs leaves this cell on a register, so cells can be placed end to end without glue logic.

Weights and terms are signed two's complement fixed-point numbers with FRAC_W fraction bits. The running sum is a wider signed integer in the same scale. A valid flag travels with each data item and marks whether that item takes part in accumulation. One package enumeration selects saturating or wrapping narrowing arithmetic. The default is saturating. Generating the walk states is the job of the surrounding array, not of this cell.

Top module: `walk_cell`

## Requirements
- R1: While rst_n is low, every output is zero and out_vld is low. This holds both at power-up and when reset is asserted in the middle of operation.
- R2: out_k, out_r, out_e and out_c equal in_k, in_r, in_e and in_c from two clock edges earlier.
- R3: out_t equals in_e from two edges earlier if in_r equalled in_k, and equals in_t otherwise.
- R4: out_w is the product of in_w and the selected term from R3, arithmetically shifted right by FRAC_W (rounding toward minus infinity). With the defaults WGT_W=16 and FRAC_W=12, 1.0 is coded as 4096. A zero selected term gives a zero weight.
- R5: If the item is valid and in_c equals in_k, out_v equals in_v plus the new weight of R4.
- R6: If in_c differs from in_k, out_v equals in_v.
- R7: If in_vld is low, out_v equals in_v whatever the tags are. The weight and the term still follow R3 and R4.
- R8: out_vld equals in_vld from two edges earlier.
- R9: In saturating mode, a product that falls outside the WGT_W range is clamped to 32767 or -32768 at the defaults.
- R10: In saturating mode, a sum that falls outside the VAL_W range is clamped to 8388607 or -8388608 at the default VAL_W=24. Adding a positive weight never lowers the sum.
- R11: A new item can be accepted every cycle, and consecutive items do not disturb one another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_vld | input | 1 | Item takes part in accumulation |
| in_k | input | IDX_W | Walk state index |
| in_r | input | IDX_W | Row tag compared by the selector |
| in_e | input | WGT_W | Row scale value, signed |
| in_t | input | WGT_W | Travelling transition term, signed |
| in_w | input | WGT_W | Walk weight, signed |
| in_c | input | IDX_W | Column tag compared by the accumulator |
| in_v | input | VAL_W | Running sum, signed |
| out_vld | output | 1 | Delayed valid flag |
| out_k | output | IDX_W | Delayed state index |
| out_r | output | IDX_W | Delayed row tag |
| out_e | output | WGT_W | Delayed row scale value |
| out_t | output | WGT_W | Selected term |
| out_w | output | WGT_W | New weight |
| out_c | output | IDX_W | Delayed column tag |
| out_v | output | VAL_W | Updated running sum |

## Verification
The stimulus covers four tag cases: both tags matching, only the row tag matching, neither matching, and the highest index value. Together these separate the selector's choice from the accumulator's gate. An invalid item with matching tags shows that the valid flag, and not only the tag compare, controls the sum. Products and sums on both sides of the representable range show saturation as distinct from wrapping. A minus-one by one-LSB product shows that the shift rounds toward minus infinity and not toward zero. A run of back-to-back items and a reset in the middle of operation check the two-stage alignment and the clearing of state.

// File: rtl/walk_cell_pkg.sv
package walk_cell_pkg;

   // Narrowing behaviour of the multiplier and accumulator results
   typedef enum logic {
      ARITH_SAT  = 1'b0,
      ARITH_WRAP = 1'b1
   } arith_e;

endpackage

// File: rtl/walk_dly.sv
module walk_dly #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (W < 1) begin : g_chk_w
      $error("walk_dly: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= '0;
      else        q_o <= d_i;
   end

endmodule

// File: rtl/walk_sat.sv
module walk_sat
   import walk_cell_pkg::*;
#(
   parameter int     IN_W  = 32,
   parameter int     OUT_W = 16,
   parameter arith_e ARITH = ARITH_SAT
) (
   input  logic signed [IN_W-1:0]  in_i,
   output logic signed [OUT_W-1:0] out_o
);

   localparam int XW = IN_W - OUT_W + 1;

   if (IN_W < OUT_W) begin : g_chk_w
      $error("walk_sat: IN_W must not be below OUT_W");
   end

   if (ARITH == ARITH_WRAP || IN_W == OUT_W) begin : g_wrap
      assign out_o = in_i[OUT_W-1:0];
   end else begin : g_clamp
      logic [XW-1:0] head;
      assign head = in_i[IN_W-1:OUT_W-1];
      always_comb begin
         if ((&head) || !(|head))  out_o = in_i[OUT_W-1:0];
         else if (in_i[IN_W-1])    out_o = {1'b1, {(OUT_W-1){1'b0}}};
         else                      out_o = {1'b0, {(OUT_W-1){1'b1}}};
      end
   end

endmodule

// File: rtl/walk_switch.sv
module walk_switch #(
   parameter int IDX_W = 8,
   parameter int WGT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic [IDX_W-1:0]        k_i,
   input  logic [IDX_W-1:0]        r_i,
   input  logic signed [WGT_W-1:0] e_i,
   input  logic signed [WGT_W-1:0] t_i,
   output logic                    vld_o,
   output logic [IDX_W-1:0]        k_o,
   output logic [IDX_W-1:0]        r_o,
   output logic signed [WGT_W-1:0] e_o,
   output logic signed [WGT_W-1:0] t_o
);

   logic                    hit;
   logic signed [WGT_W-1:0] t_sel;

   assign hit   = (r_i == k_i);
   assign t_sel = hit ? e_i : t_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         k_o   <= '0;
         r_o   <= '0;
         e_o   <= '0;
         t_o   <= '0;
      end else begin
         vld_o <= vld_i;
         k_o   <= k_i;
         r_o   <= r_i;
         e_o   <= e_i;
         t_o   <= t_sel;
      end
   end

   AST_T_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      (r_i == k_i) |=> (t_o == $past(e_i))); // R3
   AST_T_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (r_i != k_i) |=> (t_o == $past(t_i))); // R3

endmodule

// File: rtl/walk_accum.sv
module walk_accum
   import walk_cell_pkg::*;
#(
   parameter int     IDX_W  = 8,
   parameter int     WGT_W  = 16,
   parameter int     FRAC_W = 12,
   parameter int     VAL_W  = 24,
   parameter arith_e ARITH  = ARITH_SAT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    vld_i,
   input  logic [IDX_W-1:0]        k_i,
   input  logic [IDX_W-1:0]        c_i,
   input  logic signed [WGT_W-1:0] w_i,
   input  logic signed [WGT_W-1:0] t_i,
   input  logic signed [VAL_W-1:0] v_i,
   output logic                    vld_o,
   output logic [IDX_W-1:0]        k_o,
   output logic [IDX_W-1:0]        c_o,
   output logic signed [WGT_W-1:0] w_o,
   output logic signed [WGT_W-1:0] t_o,
   output logic signed [VAL_W-1:0] v_o
);

   localparam int PROD_W = 2 * WGT_W;
   localparam int SUM_W  = VAL_W + 1;
   localparam int EXT_W  = SUM_W - WGT_W;

   if (FRAC_W >= WGT_W || FRAC_W < 0) begin : g_chk_frac
      $error("walk_accum: FRAC_W must lie in 0..WGT_W-1");
   end
   if (VAL_W < WGT_W) begin : g_chk_val
      $error("walk_accum: VAL_W must not be below WGT_W");
   end

   logic signed [PROD_W-1:0] prod;
   logic signed [PROD_W-1:0] prod_sh;
   logic signed [WGT_W-1:0]  w_int;
   logic signed [SUM_W-1:0]  sum_full;
   logic signed [VAL_W-1:0]  sum_nar;
   logic                     take;
   logic signed [VAL_W-1:0]  v_nxt;

   assign prod    = w_i * t_i;
   assign prod_sh = prod >>> FRAC_W;

   walk_sat #(.IN_W(PROD_W), .OUT_W(WGT_W), .ARITH(ARITH)) u_wsat (
      .in_i  (prod_sh),
      .out_o (w_int)
   );

   assign sum_full = {v_i[VAL_W-1], v_i} + {{EXT_W{w_int[WGT_W-1]}}, w_int};

   walk_sat #(.IN_W(SUM_W), .OUT_W(VAL_W), .ARITH(ARITH)) u_vsat (
      .in_i  (sum_full),
      .out_o (sum_nar)
   );

   assign take  = vld_i && (c_i == k_i);
   assign v_nxt = take ? sum_nar : v_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_o <= 1'b0;
         k_o   <= '0;
         c_o   <= '0;
         w_o   <= '0;
         t_o   <= '0;
         v_o   <= '0;
      end else begin
         vld_o <= vld_i;
         k_o   <= k_i;
         c_o   <= c_i;
         w_o   <= w_int;
         t_o   <= t_i;
         v_o   <= v_nxt;
      end
   end

   AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!vld_i || (c_i != k_i)) |=> (v_o == $past(v_i))); // R6
   AST_W_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (t_i == '0) |=> (w_o == '0)); // R4
   if (ARITH == ARITH_SAT) begin : g_sat_chk
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
         (vld_i && (c_i == k_i) && (w_int > 0)) |=> (v_o >= $past(v_i))); // R10
   end

endmodule

// File: rtl/walk_cell.sv
module walk_cell
   import walk_cell_pkg::*;
#(
   parameter int     IDX_W  = 8,
   parameter int     WGT_W  = 16,
   parameter int     FRAC_W = 12,
   parameter int     VAL_W  = 24,
   parameter arith_e ARITH  = ARITH_SAT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_vld,
   input  logic [IDX_W-1:0]        in_k,
   input  logic [IDX_W-1:0]        in_r,
   input  logic signed [WGT_W-1:0] in_e,
   input  logic signed [WGT_W-1:0] in_t,
   input  logic signed [WGT_W-1:0] in_w,
   input  logic [IDX_W-1:0]        in_c,
   input  logic signed [VAL_W-1:0] in_v,
   output logic                    out_vld,
   output logic [IDX_W-1:0]        out_k,
   output logic [IDX_W-1:0]        out_r,
   output logic signed [WGT_W-1:0] out_e,
   output logic signed [WGT_W-1:0] out_t,
   output logic signed [WGT_W-1:0] out_w,
   output logic [IDX_W-1:0]        out_c,
   output logic signed [VAL_W-1:0] out_v
);

   localparam int SIDE_W = WGT_W + IDX_W + VAL_W;
   localparam int TAIL_W = IDX_W + WGT_W;

   if (IDX_W < 1) begin : g_chk_idx
      $error("walk_cell: IDX_W must be at least 1");
   end

   // stage 1: selector plus aligned side band
   logic                    s_vld;
   logic [IDX_W-1:0]        s_k, s_r;
   logic signed [WGT_W-1:0] s_e, s_t;
   logic [SIDE_W-1:0]       side_d, side_q;
   logic signed [WGT_W-1:0] d_w;
   logic [IDX_W-1:0]        d_c;
   logic signed [VAL_W-1:0] d_v;

   walk_switch #(.IDX_W(IDX_W), .WGT_W(WGT_W)) u_sw (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (in_vld),
      .k_i   (in_k),
      .r_i   (in_r),
      .e_i   (in_e),
      .t_i   (in_t),
      .vld_o (s_vld),
      .k_o   (s_k),
      .r_o   (s_r),
      .e_o   (s_e),
      .t_o   (s_t)
   );

   assign side_d = {in_w, in_c, in_v};

   walk_dly #(.W(SIDE_W)) u_side (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (side_d),
      .q_o   (side_q)
   );

   assign d_w = side_q[SIDE_W-1 -: WGT_W];
   assign d_c = side_q[VAL_W+IDX_W-1 -: IDX_W];
   assign d_v = side_q[VAL_W-1:0];

   // stage 2: weighting accumulator plus aligned tail
   logic [TAIL_W-1:0] tail_q;

   walk_accum #(
      .IDX_W(IDX_W), .WGT_W(WGT_W), .FRAC_W(FRAC_W),
      .VAL_W(VAL_W), .ARITH(ARITH)
   ) u_acc (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (s_vld),
      .k_i   (s_k),
      .c_i   (d_c),
      .w_i   (d_w),
      .t_i   (s_t),
      .v_i   (d_v),
      .vld_o (out_vld),
      .k_o   (out_k),
      .c_o   (out_c),
      .w_o   (out_w),
      .t_o   (out_t),
      .v_o   (out_v)
   );

   walk_dly #(.W(TAIL_W)) u_tail (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({s_r, s_e}),
      .q_o   (tail_q)
   );

   assign out_r = tail_q[TAIL_W-1 -: IDX_W];
   assign out_e = tail_q[WGT_W-1:0];

   AST_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      in_vld |=> ##1 out_vld); // R8
   AST_K_LAT: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ##1 (out_k == $past(in_k, 2))); // R2

endmodule

// File: tb/tb_walk_cell.sv
module tb_walk_cell;

   localparam int IW = 8;
   localparam int WW = 16;
   localparam int VW = 24;
   localparam int NV = 10;

   typedef struct packed {
      int k; int r; int e; int t; int w; int c; int v; int vld;
      int xt; int xw; int xv;
   } vec_t;

   // k, r, e, t, w, c, v, vld | expected t, w, v  (1.0 = 4096)
   localparam vec_t VECS [NV] = '{
      '{5,   5,   2048,  1000, 4096,   5,   100,      1, 2048,  2048,   2148},     // both match R5
      '{5,   6,   2048,  8192, 4096,   7,   100,      1, 8192,  8192,   100},      // no match R6
      '{3,   3,   -4096, 0,    6144,   3,   -500,     1, -4096, -6144,  -6644},    // negative
      '{3,   3,   4096,  0,    4096,   3,   77,       0, 4096,  4096,   77},       // invalid R7
      '{1,   1,   30000, 0,    30000,  2,   0,        1, 30000, 32767,  0},        // R9 high
      '{1,   1,   30000, 0,    -30000, 1,   0,        1, 30000, -32768, -32768},   // R9 low
      '{9,   9,   -1,    0,    1,      9,   10,       1, -1,    -1,     9},        // floor R4
      '{4,   4,   4096,  0,    4096,   4,   8388000,  1, 4096,  4096,   8388607},  // R10 high
      '{4,   4,   4096,  0,    -4096,  4,   -8388000, 1, 4096,  -4096,  -8388608}, // R10 low
      '{255, 255, 4096,  77,   4096,   255, 0,        1, 4096,  4096,   4096}      // top index
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_vld = 1'b0;
   logic [IW-1:0] in_k = '0, in_r = '0, in_c = '0;
   logic signed [WW-1:0] in_e = '0, in_t = '0, in_w = '0;
   logic signed [VW-1:0] in_v = '0;
   logic out_vld;
   logic [IW-1:0] out_k, out_r, out_c;
   logic signed [WW-1:0] out_e, out_t, out_w;
   logic signed [VW-1:0] out_v;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   walk_cell dut (
      .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_k(in_k), .in_r(in_r),
      .in_e(in_e), .in_t(in_t), .in_w(in_w), .in_c(in_c), .in_v(in_v),
      .out_vld(out_vld), .out_k(out_k), .out_r(out_r), .out_e(out_e),
      .out_t(out_t), .out_w(out_w), .out_c(out_c), .out_v(out_v)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t x);
      in_k   = x.k[IW-1:0];
      in_r   = x.r[IW-1:0];
      in_e   = x.e[WW-1:0];
      in_t   = x.t[WW-1:0];
      in_w   = x.w[WW-1:0];
      in_c   = x.c[IW-1:0];
      in_v   = x.v[VW-1:0];
      in_vld = x.vld[0];
   endtask

   task automatic expect_out(input vec_t x, input int idx);
      check($sformatf("R3 t vec%0d", idx), int'(out_t), x.xt);
      check($sformatf("R4 R9 w vec%0d", idx), int'(out_w), x.xw);
      check($sformatf("R5 R6 R7 R10 v vec%0d", idx), int'(out_v), x.xv);
      check($sformatf("R8 vld vec%0d", idx), int'(out_vld), x.vld);
      check($sformatf("R2 k vec%0d", idx), int'(out_k), x.k);
      check($sformatf("R2 r vec%0d", idx), int'(out_r), x.r);
      check($sformatf("R2 e vec%0d", idx), int'(out_e), x.e);
      check($sformatf("R2 c vec%0d", idx), int'(out_c), x.c);
   endtask

   task automatic check_zero(input string tag);
      check({tag, " vld"}, int'(out_vld), 0);
      check({tag, " k"}, int'(out_k), 0);
      check({tag, " t"}, int'(out_t), 0);
      check({tag, " w"}, int'(out_w), 0);
      check({tag, " v"}, int'(out_v), 0);
      check({tag, " e"}, int'(out_e), 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      drive(VECS[0]);
      repeat (3) @(negedge clk);
      check_zero("R1 power-up");
      rst_n = 1'b1;

      // table walk: each vector isolated, sampled two edges later
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         drive(VECS[i]);
         @(posedge clk);
         @(posedge clk);
         @(negedge clk);
         expect_out(VECS[i], i);
      end

      // R11 back-to-back stream
      @(negedge clk); drive(VECS[0]);
      @(negedge clk); drive(VECS[2]);
      @(negedge clk); expect_out(VECS[0], 100); drive(VECS[5]);
      @(negedge clk); expect_out(VECS[2], 102); drive(VECS[3]);
      @(negedge clk); expect_out(VECS[5], 105);
      @(negedge clk); expect_out(VECS[3], 103);

      // R1 reset asserted mid-stream
      drive(VECS[9]);
      @(posedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_zero("R1 mid-run");
      @(negedge clk);
      check_zero("R1 held");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 first edge after release v", int'(out_v), 0);
      @(negedge clk);
      expect_out(VECS[9], 109);

      finish_run();
   end

endmodule